// File: doc/BRIEF.md
# Upstream Ring Buffer Packer

This block serves a single device-to-host stream. User logic offers words on a ready/valid input. The block places each word into the next free slot of a ring of fixed-size buffers in host memory. It does this by raising a memory write request, with a byte address and the word, and holding the request until the memory side acknowledges it.

A buffer is handed to the host by a one-cycle release message once it fills. A partly filled buffer is also handed over when the host asks for a flush. The message names the channel, the buffer index and the number of valid bytes. A handed-over buffer stays locked until the host returns its index on the free input. When the current buffer is locked, input stalls.

A second message kind tells the host that the channel has gone from holding nothing to holding data. This lets a polling host wake up before any buffer is released. A configuration input can suppress this message.

Top module: `upstream_ring_mgr`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `wr_req` is 0, `msg_valid` is 0, and the first buffer filled is index 0.
- R2: An accepted word launches a write request in the next cycle. The address is BASE_ADDR + index*BUF_BYTES + slot*(WORD_BITS/8). The data is the accepted word. Address and data stay unchanged until the cycle where `wr_ack` is sampled high. No word is accepted while a request is open.
- R3: The acknowledge that completes the last slot of a buffer produces, in the next cycle, a one-cycle release message. A release has `msg_kind`=0, `msg_chan`=CHAN_ID, the buffer index and `msg_bytes`=BUF_BYTES.
- R4: Buffers are filled and released in ring order: index N is followed by (N+1) mod NUM_BUFS.
- R5: A flush request seen while the current buffer holds k>0 words submits that buffer at the first edge with no write open. The release message carries `msg_bytes`=k*(WORD_BITS/8). No word is accepted while such a flush waits.
- R6: A flush request seen while the current buffer holds no words produces no message. It stays pending until a word completes, and that partial buffer is then submitted as in R5.
- R7: A released buffer is locked. `in_ready` is 0 whenever the current buffer is locked. A pulse on `free_valid` unlocks buffer `free_idx`. Freeing a buffer that is not locked has no effect.
- R8: With `nonempty_en`=1, a write acknowledge that completes while no buffer is locked and the current buffer holds no words produces, in the next cycle, one message with `msg_kind`=1, `msg_chan`=CHAN_ID, `msg_buf` = current index and `msg_bytes`=0.
- R9: With `nonempty_en`=0, the `msg_kind`=1 message is never produced.
- R10: The `msg_kind`=1 message is produced again only after every released buffer has been freed and the current buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nonempty_en | input | 1 | Enables the empty-to-data message |
| in_valid | input | 1 | Input word offered |
| in_data | input | WORD_BITS | Input word |
| in_ready | output | 1 | Input word taken at this edge when also valid |
| wr_req | output | 1 | Memory write request open |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | WORD_BITS | Data of the write |
| wr_ack | input | 1 | Memory side completes the open request |
| flush_req | input | 1 | Host asks for the partial buffer to be submitted |
| free_valid | input | 1 | Host returns a buffer |
| free_idx | input | IDX_W | Index of the returned buffer |
| msg_valid | output | 1 | Message present for one cycle |
| msg_kind | output | 1 | 0 = buffer release, 1 = channel became non-empty |
| msg_chan | output | 8 | Channel number |
| msg_buf | output | IDX_W | Buffer index |
| msg_bytes | output | CNT_W | Valid bytes in the released buffer (0 for kind 1) |

## Verification
A wrong fill count shows on the very next write as a wrong slot in `wr_addr`. At the next release it also shows as a wrong `msg_bytes`. A wrong ring index or a lost lock bit shows within one buffer's worth of words, as a release for the wrong index or as `in_ready` staying high over a buffer the host still owns. A stale emptiness view shows as a missing or extra kind-1 message one cycle after the acknowledge that should or should not produce it. The bench therefore compares every output on every cycle against a behavioural model, so each of these faults is caught on the cycle where it first appears.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam int MSG_IDX_BITS = 8;
    localparam int MSG_CNT_BITS = 16;

    typedef enum logic {
        MSG_RELEASE  = 1'b0,
        MSG_NONEMPTY = 1'b1
    } msg_kind_e;

    typedef struct packed {
        logic                    valid;
        msg_kind_e               kind;
        logic [MSG_IDX_BITS-1:0] idx;
        logic [MSG_CNT_BITS-1:0] bytes;
    } msg_rec_t;

    function automatic int word_bytes(input int bits);
        return bits / 8;
    endfunction

    function automatic int idx_bits(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/ring_lock_table.sv
module ring_lock_table #(
    parameter int NUM_BUFS = 4,
    parameter int IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             free_en,
    input  logic [IDX_W-1:0] free_idx,
    input  logic [IDX_W-1:0] cur_idx,
    output logic             cur_locked,
    output logic             any_locked
);

    logic [NUM_BUFS-1:0] lock_q;

    for (genvar g = 0; g < NUM_BUFS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_q[g] <= 1'b0;
            end else if (set_en && (set_idx == IDX_W'(g))) begin
                lock_q[g] <= 1'b1;
            end else if (free_en && (free_idx == IDX_W'(g))) begin
                lock_q[g] <= 1'b0;
            end
        end
    end

    assign cur_locked = lock_q[cur_idx];
    assign any_locked = |lock_q;

endmodule

// File: rtl/ring_fill_ctrl.sv
module ring_fill_ctrl #(
    parameter int          NUM_BUFS  = 4,
    parameter int          BUF_BYTES = 32,
    parameter int          WORD_BITS = 16,
    parameter int          ADDR_W    = 32,
    parameter int unsigned BASE_ADDR = 32'h0001_0000,
    parameter int          IDX_W     = 2,
    parameter int          CNT_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [WORD_BITS-1:0] in_data,
    output logic                 in_ready,
    output logic                 wr_req,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [WORD_BITS-1:0] wr_data,
    input  logic                 wr_ack,
    input  logic                 flush_req,
    input  logic                 cur_locked,
    input  logic                 any_locked,
    output logic [IDX_W-1:0]     cur_idx,
    output logic                 sub_fire,
    output logic [CNT_W-1:0]     sub_bytes,
    output logic                 first_fire
);

    localparam int WB     = ring_pkg::word_bytes(WORD_BITS);
    localparam int WPB    = BUF_BYTES / WB;
    localparam int SLOT_W = $clog2(WPB) + 1;
    localparam int BUF_SH = $clog2(BUF_BYTES);
    localparam int WB_SH  = $clog2(WB);

    logic                 busy_q;
    logic [IDX_W-1:0]     idx_q;
    logic [SLOT_W-1:0]    fill_q;
    logic                 flush_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [WORD_BITS-1:0] data_q;

    logic ack_done, has_fill, flush_want, full_done, flush_fire, accept;
    logic [ADDR_W-1:0] slot_addr;
    logic [IDX_W-1:0]  idx_next;

    always_comb begin
        ack_done   = busy_q & wr_ack;
        has_fill   = (fill_q != '0);
        flush_want = flush_q | flush_req;
        full_done  = ack_done && (fill_q == SLOT_W'(WPB - 1));
        flush_fire = !busy_q && flush_want && has_fill;
        in_ready   = !busy_q && !cur_locked && !(flush_want && has_fill);
        accept     = in_valid && in_ready;
        slot_addr  = ADDR_W'(BASE_ADDR)
                   + ((ADDR_W'(idx_q) << BUF_SH) | (ADDR_W'(fill_q) << WB_SH));
        idx_next   = (idx_q == IDX_W'(NUM_BUFS - 1)) ? '0 : idx_q + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            fill_q  <= '0;
            flush_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            if (accept) begin
                busy_q <= 1'b1;
                addr_q <= slot_addr;
                data_q <= in_data;
            end
            if (ack_done) begin
                busy_q <= 1'b0;
                fill_q <= full_done ? '0 : fill_q + SLOT_W'(1);
            end
            if (flush_fire) begin
                fill_q <= '0;
            end
            if (full_done || flush_fire) begin
                idx_q <= idx_next;
            end
            if (flush_fire) begin
                flush_q <= 1'b0;
            end else if (flush_req) begin
                flush_q <= 1'b1;
            end
        end
    end

    assign wr_req     = busy_q;
    assign wr_addr    = addr_q;
    assign wr_data    = data_q;
    assign cur_idx    = idx_q;
    assign sub_fire   = full_done || flush_fire;
    assign sub_bytes  = full_done ? CNT_W'(BUF_BYTES) : (CNT_W'(fill_q) << WB_SH);
    assign first_fire = ack_done && !any_locked && !has_fill;

endmodule

// File: rtl/ring_msg_out.sv
module ring_msg_out #(
    parameter int IDX_W = 2,
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ne_en,
    input  logic              sub_fire,
    input  logic [IDX_W-1:0]  sub_idx,
    input  logic [CNT_W-1:0]  sub_bytes,
    input  logic              first_fire,
    output ring_pkg::msg_rec_t msg
);

    import ring_pkg::*;

    msg_rec_t msg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q <= '0;
        end else begin
            msg_q.valid <= 1'b0;
            if (sub_fire) begin
                msg_q.valid <= 1'b1;
                msg_q.kind  <= MSG_RELEASE;
                msg_q.idx   <= MSG_IDX_BITS'(sub_idx);
                msg_q.bytes <= MSG_CNT_BITS'(sub_bytes);
            end else if (first_fire && ne_en) begin
                msg_q.valid <= 1'b1;
                msg_q.kind  <= MSG_NONEMPTY;
                msg_q.idx   <= MSG_IDX_BITS'(sub_idx);
                msg_q.bytes <= '0;
            end
        end
    end

    assign msg = msg_q;

endmodule

// File: rtl/upstream_ring_mgr.sv
module upstream_ring_mgr #(
    parameter int          NUM_BUFS  = 4,
    parameter int          BUF_BYTES = 32,
    parameter int          WORD_BITS = 16,
    parameter int          CHAN_ID   = 3,
    parameter int          ADDR_W    = 32,
    parameter int unsigned BASE_ADDR = 32'h0001_0000,
    localparam int         IDX_W     = ring_pkg::idx_bits(NUM_BUFS),
    localparam int         CNT_W     = $clog2(BUF_BYTES) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 nonempty_en,
    input  logic                 in_valid,
    input  logic [WORD_BITS-1:0] in_data,
    output logic                 in_ready,
    output logic                 wr_req,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [WORD_BITS-1:0] wr_data,
    input  logic                 wr_ack,
    input  logic                 flush_req,
    input  logic                 free_valid,
    input  logic [IDX_W-1:0]     free_idx,
    output logic                 msg_valid,
    output logic                 msg_kind,
    output logic [7:0]           msg_chan,
    output logic [IDX_W-1:0]     msg_buf,
    output logic [CNT_W-1:0]     msg_bytes
);

    import ring_pkg::*;

    logic              cur_locked, any_locked, sub_fire, first_fire;
    logic [IDX_W-1:0]  cur_idx;
    logic [CNT_W-1:0]  sub_bytes;
    msg_rec_t          msg;

    ring_fill_ctrl #(
        .NUM_BUFS (NUM_BUFS),
        .BUF_BYTES(BUF_BYTES),
        .WORD_BITS(WORD_BITS),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) fill_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_ack    (wr_ack),
        .flush_req (flush_req),
        .cur_locked(cur_locked),
        .any_locked(any_locked),
        .cur_idx   (cur_idx),
        .sub_fire  (sub_fire),
        .sub_bytes (sub_bytes),
        .first_fire(first_fire)
    );

    ring_lock_table #(
        .NUM_BUFS(NUM_BUFS),
        .IDX_W   (IDX_W)
    ) lock_i (
        .clk       (clk),
        .rst       (rst),
        .set_en    (sub_fire),
        .set_idx   (cur_idx),
        .free_en   (free_valid),
        .free_idx  (free_idx),
        .cur_idx   (cur_idx),
        .cur_locked(cur_locked),
        .any_locked(any_locked)
    );

    ring_msg_out #(
        .IDX_W(IDX_W),
        .CNT_W(CNT_W)
    ) msg_i (
        .clk       (clk),
        .rst       (rst),
        .ne_en     (nonempty_en),
        .sub_fire  (sub_fire),
        .sub_idx   (cur_idx),
        .sub_bytes (sub_bytes),
        .first_fire(first_fire),
        .msg       (msg)
    );

    assign msg_valid = msg.valid;
    assign msg_kind  = msg.kind;
    assign msg_chan  = 8'(CHAN_ID);
    assign msg_buf   = msg.idx[IDX_W-1:0];
    assign msg_bytes = msg.bytes[CNT_W-1:0];

endmodule

// File: rtl/ring_mgr_chk.sv
module ring_mgr_chk #(
    parameter int NUM_BUFS  = 4,
    parameter int BUF_BYTES = 32,
    parameter int WORD_BITS = 16,
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 2,
    parameter int CNT_W     = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 wr_req,
    input logic                 wr_ack,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [WORD_BITS-1:0] wr_data,
    input logic                 msg_valid,
    input logic                 msg_kind,
    input logic [IDX_W-1:0]     msg_buf,
    input logic [CNT_W-1:0]     msg_bytes
);

    logic [IDX_W-1:0] ring_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_exp <= '0;
        end else if (msg_valid && !msg_kind) begin
            ring_exp <= (ring_exp == IDX_W'(NUM_BUFS - 1)) ? '0 : ring_exp + IDX_W'(1);
        end
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

    // R2
    accept_launch_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> wr_req);

    // R2
    no_take_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> !in_ready);

    // R3
    rel_size_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_kind |-> (msg_bytes != '0) && (msg_bytes <= CNT_W'(BUF_BYTES)));

    // R3
    full_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_kind && (msg_bytes == CNT_W'(BUF_BYTES)) |-> $past(wr_req && wr_ack));

    // R4
    ring_order_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_kind |-> msg_buf == ring_exp);

    // R8
    nonempty_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_kind |-> $past(wr_req && wr_ack) && (msg_bytes == '0));

endmodule

bind upstream_ring_mgr ring_mgr_chk #(
    .NUM_BUFS (NUM_BUFS),
    .BUF_BYTES(BUF_BYTES),
    .WORD_BITS(WORD_BITS),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .wr_req   (wr_req),
    .wr_ack   (wr_ack),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .msg_valid(msg_valid),
    .msg_kind (msg_kind),
    .msg_buf  (msg_buf),
    .msg_bytes(msg_bytes)
);

// File: tb/upstream_ring_mgr_tb_top.sv
`timescale 1ns/1ps
module upstream_ring_mgr_tb_top;

    localparam int          NB   = 4;
    localparam int          BB   = 16;
    localparam int          WBIT = 32;
    localparam int          WBY  = WBIT / 8;
    localparam int          WPB  = BB / WBY;
    localparam int          CH   = 5;
    localparam int unsigned BASE = 32'h0004_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nonempty_en = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        wr_req;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_ack = 1'b0;
    logic        flush_req = 1'b0;
    logic        free_valid = 1'b0;
    logic [1:0]  free_idx = '0;
    logic        msg_valid;
    logic        msg_kind;
    logic [7:0]  msg_chan;
    logic [1:0]  msg_buf;
    logic [4:0]  msg_bytes;

    always #4 clk = ~clk;

    upstream_ring_mgr #(
        .NUM_BUFS(NB), .BUF_BYTES(BB), .WORD_BITS(WBIT),
        .CHAN_ID(CH), .ADDR_W(32), .BASE_ADDR(BASE)
    ) dut_i (
        .clk(clk), .rst(rst), .nonempty_en(nonempty_en),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .flush_req(flush_req), .free_valid(free_valid), .free_idx(free_idx),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_chan(msg_chan),
        .msg_buf(msg_buf), .msg_bytes(msg_bytes)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int ne_seen  = 0;
    int rel_seen = 0;
    int last_buf = 0;
    int last_bytes = 0;
    int ack_lat  = 1;
    bit done     = 0;

    // reference model state
    int m_cur, m_fill, m_lockn;
    bit m_busy, m_flushp;
    bit m_lock [NB];
    int e_addr, e_data, e_buf, e_bytes;
    bit e_mv, e_kind;
    bit was_empty, rdy_now, fl_used, do_lock;
    int lock_at;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit model_ready();
        return !m_busy && !m_lock[m_cur] && !((m_flushp || flush_req) && m_fill != 0);
    endfunction

    function automatic int lock_count();
        int c = 0;
        for (int i = 0; i < NB; i++) c += m_lock[i];
        return c;
    endfunction

    // behavioural reference, advanced on each rising edge from the bench's own inputs
    always @(posedge clk) begin
        if (rst) begin
            m_cur = 0; m_fill = 0; m_busy = 0; m_flushp = 0; e_mv = 0;
            for (int i = 0; i < NB; i++) m_lock[i] = 0;
        end else begin
            rdy_now   = model_ready();
            was_empty = (lock_count() == 0) && (m_fill == 0);
            e_mv = 0; fl_used = 0; do_lock = 0; lock_at = 0;
            if (m_busy && wr_ack) begin
                m_busy = 0;
                if (was_empty && nonempty_en) begin
                    e_mv = 1; e_kind = 1; e_buf = m_cur; e_bytes = 0;
                end
                m_fill++;
                if (m_fill == WPB) begin
                    do_lock = 1; lock_at = m_cur;
                    e_mv = 1; e_kind = 0; e_buf = m_cur; e_bytes = BB;
                    m_cur = (m_cur + 1) % NB; m_fill = 0;
                end
            end else if (!m_busy && (m_flushp || flush_req) && m_fill != 0) begin
                do_lock = 1; lock_at = m_cur;
                e_mv = 1; e_kind = 0; e_buf = m_cur; e_bytes = m_fill * WBY;
                m_cur = (m_cur + 1) % NB; m_fill = 0; m_flushp = 0; fl_used = 1;
            end else if (rdy_now && in_valid) begin
                m_busy = 1;
                e_addr = BASE + m_cur * BB + m_fill * WBY;
                e_data = in_data;
            end
            if (flush_req && !fl_used) m_flushp = 1;
            if (free_valid) m_lock[free_idx] = 0;
            if (do_lock) m_lock[lock_at] = 1;
        end
    end

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(in_ready == model_ready(), "R7", "in_ready", in_ready, model_ready());
            chk(wr_req == m_busy, "R2", "wr_req", wr_req, m_busy);
            if (wr_req && m_busy) begin
                chk(wr_addr == 32'(e_addr), "R2", "wr_addr", wr_addr, e_addr);
                chk(wr_data == 32'(e_data), "R2", "wr_data", wr_data, e_data);
            end
            chk(msg_valid == e_mv, "R3", "msg_valid", msg_valid, e_mv);
            if (msg_valid && e_mv) begin
                chk(msg_kind == e_kind, "R8", "msg_kind", msg_kind, e_kind);
                chk(msg_chan == 8'(CH), "R3", "msg_chan", msg_chan, CH);
                chk(msg_buf == 2'(e_buf), "R4", "msg_buf", msg_buf, e_buf);
                chk(msg_bytes == 5'(e_bytes), "R5", "msg_bytes", msg_bytes, e_bytes);
            end
            if (msg_valid) begin
                if (msg_kind) ne_seen++;
                else begin
                    rel_seen++; last_buf = msg_buf; last_bytes = msg_bytes;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic send_word(input logic [31:0] d);
        in_valid = 1'b1; in_data = d;
        forever begin
            #1;
            if (in_ready) begin tick(); break; end
            tick();
        end
        in_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush_req = 1'b1; tick(); flush_req = 1'b0;
    endtask

    task automatic do_free(input int i);
        free_valid = 1'b1; free_idx = 2'(i); tick(); free_valid = 1'b0;
    endtask

    // memory side: acknowledges an open request after ack_lat cycles
    initial begin
        int cnt = 0;
        forever begin
            tick();
            if (wr_req && !wr_ack) begin
                if (cnt >= ack_lat) begin wr_ack = 1'b1; cnt = 0; end
                else cnt++;
            end else begin
                wr_ack = 1'b0;
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #2 rst = 1'b0;
        #1;
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(wr_req == 1'b0, "R1", "wr_req after reset", wr_req, 0);
        chk(msg_valid == 1'b0, "R1", "msg_valid after reset", msg_valid, 0);
        tick();

        // R3 R8: one full buffer with the empty-to-data message
        for (int i = 0; i < WPB; i++) send_word(32'hA000_0000 + i);
        idle(6);
        chk(ne_seen == 1, "R8", "nonempty count", ne_seen, 1);
        chk(rel_seen == 1, "R3", "release count", rel_seen, 1);
        chk(last_bytes == BB, "R3", "full bytes", last_bytes, BB);
        chk(last_buf == 0, "R1", "first buffer index", last_buf, 0);

        // R6: flush with nothing in the current buffer stays pending
        do_flush();
        idle(6);
        chk(rel_seen == 1, "R6", "no release on empty flush", rel_seen, 1);
        send_word(32'hB000_0001);
        idle(6);
        chk(rel_seen == 2, "R6", "pending flush submits", rel_seen, 2);
        chk(last_bytes == WBY, "R5", "partial bytes", last_bytes, WBY);
        chk(last_buf == 1, "R4", "ring index", last_buf, 1);
        chk(ne_seen == 1, "R10", "no rearm while locked", ne_seen, 1);

        // R7: fill the rest of the ring and stall
        for (int i = 0; i < 2 * WPB; i++) send_word(32'hC000_0000 + i);
        idle(6);
        chk(rel_seen == 4, "R4", "ring wrapped", rel_seen, 4);
        #1 chk(in_ready == 1'b0, "R7", "stall when all locked", in_ready, 0);
        do_free(2);
        #1 chk(in_ready == 1'b0, "R7", "stall while current locked", in_ready, 0);
        do_free(0);
        #1 chk(in_ready == 1'b1, "R7", "ready after free", in_ready, 1);
        do_free(0);
        #1 chk(in_ready == 1'b1, "R7", "free of unlocked ignored", in_ready, 1);

        // R10: re-arm after all freed; R9: disabled message
        do_free(1);
        do_free(3);
        send_word(32'hD000_0000);
        idle(6);
        chk(ne_seen == 2, "R10", "rearmed nonempty", ne_seen, 2);
        do_flush();
        idle(4);
        do_free(0);
        nonempty_en = 1'b0;
        send_word(32'hD000_0001);
        idle(6);
        chk(ne_seen == 2, "R9", "suppressed nonempty", ne_seen, 2);
        do_flush();
        idle(4);
        chk(rel_seen == 6, "R5", "flush releases", rel_seen, 6);
        do_free(1);

        // R5: flush raised while a write is open
        nonempty_en = 1'b1;
        ack_lat = 3;
        send_word(32'hE000_0000);
        do_flush();
        idle(10);
        chk(ne_seen == 3, "R8", "nonempty before release", ne_seen, 3);
        chk(rel_seen == 7, "R5", "release after open write", rel_seen, 7);
        chk(last_bytes == WBY, "R5", "bytes after open write", last_bytes, WBY);
        do_free(2);

        // mixed traffic against the model
        for (int c = 0; c < 3000; c++) begin
            in_valid   = ($urandom % 3) != 0;
            in_data    = $urandom;
            flush_req  = ($urandom % 20) == 0;
            free_valid = ($urandom % 5) == 0;
            free_idx   = 2'($urandom % NB);
            if (c % 50 == 0) ack_lat = $urandom % 3;
            tick();
        end
        in_valid = 1'b0; flush_req = 1'b0; free_valid = 1'b0;
        idle(10);
        finish_run();
    end

endmodule